// File: doc/BRIEF.md
# Event Stream Decoder with Timestamp Extension

This block sits on a detector readout link that delivers 32-bit words, two per item. It sorts each item into an ADC hit or an information item and gives it a full 48-bit time. The low 28 bits of the time come from the second word of the item. The high 20 bits come from a per-module table. Information items that carry upper time bits (pause, resume, periodic sync and extended stamp) update that table. Periodic sync items arrive about every 655 µs, so the table is refreshed many times before the 28-bit stamp wraps, which takes about 2.7 s.

Trace-buffer headers are not forwarded. The block follows them only to count off and discard their packed 16-bit sample words. Link-statistics items carry a buffer count in place of a stamp. That count is passed through unmerged and never touches the table. A malformed word raises a framing-error pulse, and the decoder then resynchronises on the next plausible first word. Decoded items leave through a single output register with a valid/ready handshake. Pause and resume items also produce one-cycle status strobes tagged with the module number.

Top module: `evt_ts_decoder`

## Requirements
- R1: After reset `out_valid`, `ts_pause`, `ts_resume` and `frame_err` are 0, `in_ready` is 1, and every module's table entry is empty, so items that rely on the table report `out_time_ok` = 0 with high time bits zero.
- R2: An item whose first word has bits 31:30 = 11 is emitted with `out_kind` = 1, `out_src` = first-word bits 27:16, `out_flags` = {bit 29, bit 28}, `out_payload` = {4'b0, bits 15:0} and `out_code` = 0.
- R3: An item whose first word has bits 31:30 = 10 is emitted with `out_kind` = 2, `out_src` = {6'b0, bits 29:24}, `out_code` = bits 23:20 and `out_payload` = bits 19:0.
- R4: An information item with code 2, 3, 4 or 7 stores its 20-bit field as the high time of its module, and is itself emitted with `out_time` = {field, second-word bits 27:0} and `out_time_ok` = 1.
- R5: Every other ADC or information item gets `out_time` = {stored high bits of its module, second-word bits 27:0} and `out_time_ok` = 1 only if that module has an entry. For ADC items the module is channel-ident bits 11:6.
- R6: An information item with code 14 or 15 is emitted with `out_time_ok` = 0 and `out_time` = {20'b0, second-word bits 27:0}, and it leaves the table unchanged.
- R7: A first word with bits 31:28 = 0100 starts a trace header. Neither it nor its second word is emitted, and the following ceil(N/2) words are discarded, where N is first-word bits 15:0.
- R8: A second word whose bits 31:28 are not zero drops the item and pulses `frame_err` for one cycle. Words with bits 31:30 = 00 are then discarded silently until a word with bits 31:30 ≠ 00 starts a new item.
- R9: While the decoder is aligned, a first word with bits 31:30 = 00, or with bits 31:28 equal to 0101, 0110 or 0111, pulses `frame_err` and is dropped.
- R10: An accepted code-2 item pulses `ts_pause`, and a code-3 item pulses `ts_resume`, for one cycle. The pulse comes together with the item's `out_valid`, and `ts_pulse_mod` gives the module number.
- R11: While `out_valid` = 1 and `out_ready` = 0, every output field holds steady and `in_ready` = 0.
- R12: Table entries are independent: a timestamp update for one module does not change the time or `out_time_ok` of items from another module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder can take a word |
| in_data | input | 32 | Link word |
| out_valid | output | 1 | Decoded item available |
| out_ready | input | 1 | Consumer takes the item |
| out_kind | output | 2 | 1 = ADC hit, 2 = information item |
| out_src | output | 12 | Channel ident (ADC) or module number (information) |
| out_flags | output | 2 | {fail, veto/range} for ADC items |
| out_code | output | 4 | Information code |
| out_payload | output | 20 | ADC value or information field |
| out_time | output | 48 | Extended time, or buffer count for link statistics |
| out_time_ok | output | 1 | High time bits are known |
| ts_pause | output | 1 | Pause item seen |
| ts_resume | output | 1 | Resume item seen |
| ts_pulse_mod | output | 6 | Module of the pause/resume strobe |
| frame_err | output | 1 | Framing-error strobe |

## Verification
ADC hits are sent both before and after their module's sync. The two cases differ in `out_time_ok` and in the high time bits, which shows that the table is read and not just passed through. A second module with no entry and a link-statistics item sent after a sync show that table entries are kept apart and that a buffer count never leaks into the stored time. Trace headers whose sample words look like ADC and information words, a corrupt second word followed by filler, and a stray first word show the difference between skipping, resynchronising and reporting. A stalled consumer shows that the output holds and that input is refused.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int WORD_W    = 32;
    localparam int LO_TS_W   = 28;
    localparam int HI_TS_W   = 20;
    localparam int TS_W      = LO_TS_W + HI_TS_W;
    localparam int MOD_W     = 6;
    localparam int IDENT_W   = 12;
    localparam int FIELD_W   = 20;
    localparam int CODE_W    = 4;
    localparam int ADCVAL_W  = 16;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_ADC   = 2'd1,
        KIND_INFO  = 2'd2,
        KIND_TRACE = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        FR_FIRST  = 2'd0,
        FR_SECOND = 2'd1,
        FR_SKIP   = 2'd2,
        FR_HUNT   = 2'd3
    } fr_state_e;

    typedef struct packed {
        kind_e               kind;
        logic [IDENT_W-1:0]  src;
        logic [1:0]          flags;
        logic [CODE_W-1:0]   code;
        logic [FIELD_W-1:0]  payload;
        logic [TS_W-1:0]     time_v;
        logic                time_ok;
    } evt_item_t;

    function automatic kind_e word_kind(input logic [WORD_W-1:0] w);
        if (w[31:30] == 2'b11)      return KIND_ADC;
        else if (w[31:30] == 2'b10) return KIND_INFO;
        else if (w[31:28] == 4'b0100) return KIND_TRACE;
        else return KIND_NONE;
    endfunction

    function automatic logic carries_high_ts(input logic [CODE_W-1:0] c);
        return (c == 4'd2) || (c == 4'd3) || (c == 4'd4) || (c == 4'd7);
    endfunction

    function automatic logic is_link_count(input logic [CODE_W-1:0] c);
        return (c == 4'd14) || (c == 4'd15);
    endfunction

endpackage

// File: rtl/evt_framer.sv
module evt_framer
    import evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              accept_ok,
    output logic              in_ready,
    output logic              item_stb,
    output logic              ferr_stb,
    output logic [WORD_W-1:0] first_q
);

    fr_state_e          st_q, st_d;
    logic [WORD_W-1:0]  first_d;
    logic [CNT_W-1:0]   skip_q, skip_d;
    logic [CNT_W:0]     words_wide;
    logic [CNT_W-1:0]   words_need;
    logic               fire;
    kind_e              in_kind;

    assign in_ready   = accept_ok;
    assign fire       = in_valid && accept_ok;
    assign in_kind    = word_kind(in_data);
    assign words_wide = ({1'b0, first_q[CNT_W-1:0]} + {{CNT_W{1'b0}}, 1'b1}) >> 1;
    assign words_need = words_wide[CNT_W-1:0];

    always_comb begin
        st_d     = st_q;
        first_d  = first_q;
        skip_d   = skip_q;
        item_stb = 1'b0;
        ferr_stb = 1'b0;
        if (fire) begin
            case (st_q)
                FR_FIRST: begin
                    if (in_kind == KIND_NONE) begin
                        ferr_stb = 1'b1;
                    end else begin
                        first_d = in_data;
                        st_d    = FR_SECOND;
                    end
                end
                FR_HUNT: begin
                    if (in_kind != KIND_NONE && in_data[31:30] != 2'b00) begin
                        first_d = in_data;
                        st_d    = FR_SECOND;
                    end
                end
                FR_SECOND: begin
                    if (in_data[31:28] != 4'd0) begin
                        ferr_stb = 1'b1;
                        st_d     = FR_HUNT;
                    end else if (word_kind(first_q) == KIND_TRACE) begin
                        if (words_need == '0) begin
                            st_d = FR_FIRST;
                        end else begin
                            skip_d = words_need;
                            st_d   = FR_SKIP;
                        end
                    end else begin
                        item_stb = 1'b1;
                        st_d     = FR_FIRST;
                    end
                end
                default: begin
                    skip_d = skip_q - 1'b1;
                    if (skip_q == {{(CNT_W-1){1'b0}}, 1'b1}) st_d = FR_FIRST;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FR_FIRST;
            first_q <= '0;
            skip_q  <= '0;
        end else begin
            st_q    <= st_d;
            first_q <= first_d;
            skip_q  <= skip_d;
        end
    end

    AST_SKIP_NONZERO: assert property (@(posedge clk) disable iff (rst)
        st_q == FR_SKIP |-> skip_q != '0) else $error("skip count empty in skip state"); // R7

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        st_q == FR_SKIP |-> !item_stb && !ferr_stb) else $error("skipped word produced an item"); // R7

endmodule

// File: rtl/evt_ts_table.sv
module evt_ts_table #(
    parameter int MOD_W = 6,
    parameter int HI_W  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [MOD_W-1:0] wr_mod,
    input  logic [HI_W-1:0]  wr_hi,
    input  logic [MOD_W-1:0] rd_mod,
    output logic [HI_W-1:0]  rd_hi,
    output logic             rd_ok
);

    localparam int DEPTH = 1 << MOD_W;

    logic [HI_W-1:0] hi_q [DEPTH];
    logic [DEPTH-1:0] ok_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                hi_q[g] <= '0;
                ok_q[g] <= 1'b0;
            end else if (wr_en && wr_mod == MOD_W'(g)) begin
                hi_q[g] <= wr_hi;
                ok_q[g] <= 1'b1;
            end
        end
    end

    assign rd_hi = hi_q[rd_mod];
    assign rd_ok = ok_q[rd_mod];

    AST_EMPTY_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_ok |-> rd_hi == '0) else $error("empty entry holds data"); // R1

endmodule

// File: rtl/evt_assemble.sv
module evt_assemble
    import evt_pkg::*;
#(
    parameter int ADC_MOD_LSB = 6
) (
    input  logic [WORD_W-1:0]  w0,
    input  logic [WORD_W-1:0]  w1,
    input  logic [HI_TS_W-1:0] tbl_hi,
    input  logic               tbl_ok,
    output logic [MOD_W-1:0]   lookup_mod,
    output logic               ts_write,
    output logic               is_pause,
    output logic               is_resume,
    output evt_item_t          item
);

    kind_e               k;
    logic [CODE_W-1:0]   code;
    logic [FIELD_W-1:0]  field;
    logic [IDENT_W-1:0]  ident;
    logic [LO_TS_W-1:0]  lo;
    logic                unused_hi;

    assign k         = word_kind(w0);
    assign code      = w0[23:20];
    assign field     = w0[19:0];
    assign ident     = w0[27:16];
    assign lo        = w1[LO_TS_W-1:0];
    assign unused_hi = ^w1[WORD_W-1:LO_TS_W];

    always_comb begin
        item         = '0;
        ts_write     = 1'b0;
        is_pause     = 1'b0;
        is_resume    = 1'b0;
        lookup_mod   = w0[29:24];
        item.time_v  = {tbl_hi, lo};
        item.time_ok = tbl_ok;
        if (k == KIND_ADC) begin
            lookup_mod   = ident[ADC_MOD_LSB +: MOD_W];
            item.kind    = KIND_ADC;
            item.src     = ident;
            item.flags   = w0[29:28];
            item.payload = {{(FIELD_W-ADCVAL_W){1'b0}}, w0[ADCVAL_W-1:0]};
        end else begin
            item.kind    = KIND_INFO;
            item.src     = {{(IDENT_W-MOD_W){1'b0}}, w0[29:24]};
            item.code    = code;
            item.payload = field;
            if (carries_high_ts(code)) begin
                ts_write     = 1'b1;
                item.time_v  = {field, lo};
                item.time_ok = 1'b1;
                is_pause     = (code == 4'd2);
                is_resume    = (code == 4'd3);
            end else if (is_link_count(code)) begin
                item.time_v  = {{HI_TS_W{1'b0}}, lo};
                item.time_ok = 1'b0;
            end
        end
    end

endmodule

// File: rtl/evt_ts_decoder.sv
module evt_ts_decoder
    import evt_pkg::*;
#(
    parameter int ADC_MOD_LSB = 6,
    parameter int CNT_W       = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [1:0]  out_kind,
    output logic [11:0] out_src,
    output logic [1:0]  out_flags,
    output logic [3:0]  out_code,
    output logic [19:0] out_payload,
    output logic [47:0] out_time,
    output logic        out_time_ok,
    output logic        ts_pause,
    output logic        ts_resume,
    output logic [5:0]  ts_pulse_mod,
    output logic        frame_err
);

    logic              accept_ok;
    logic              item_stb;
    logic              ferr_stb;
    logic [WORD_W-1:0] first_q;
    logic [MOD_W-1:0]  lookup_mod;
    logic [HI_TS_W-1:0] tbl_hi;
    logic              tbl_ok;
    logic              ts_write;
    logic              is_pause;
    logic              is_resume;
    evt_item_t         item;
    evt_item_t         out_q;

    assign accept_ok = !out_valid || out_ready;

    evt_framer #(.CNT_W(CNT_W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .accept_ok (accept_ok),
        .in_ready  (in_ready),
        .item_stb  (item_stb),
        .ferr_stb  (ferr_stb),
        .first_q   (first_q)
    );

    evt_assemble #(.ADC_MOD_LSB(ADC_MOD_LSB)) u_assemble (
        .w0         (first_q),
        .w1         (in_data),
        .tbl_hi     (tbl_hi),
        .tbl_ok     (tbl_ok),
        .lookup_mod (lookup_mod),
        .ts_write   (ts_write),
        .is_pause   (is_pause),
        .is_resume  (is_resume),
        .item       (item)
    );

    evt_ts_table #(.MOD_W(MOD_W), .HI_W(HI_TS_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (item_stb && ts_write),
        .wr_mod (lookup_mod),
        .wr_hi  (item.payload),
        .rd_mod (lookup_mod),
        .rd_hi  (tbl_hi),
        .rd_ok  (tbl_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_q        <= '0;
            ts_pause     <= 1'b0;
            ts_resume    <= 1'b0;
            ts_pulse_mod <= '0;
            frame_err    <= 1'b0;
        end else begin
            if (item_stb) begin
                out_valid <= 1'b1;
                out_q     <= item;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
            ts_pause  <= item_stb && is_pause;
            ts_resume <= item_stb && is_resume;
            frame_err <= ferr_stb;
            if (item_stb && (is_pause || is_resume)) ts_pulse_mod <= lookup_mod;
        end
    end

    assign out_kind    = out_q.kind;
    assign out_src     = out_q.src;
    assign out_flags   = out_q.flags;
    assign out_code    = out_q.code;
    assign out_payload = out_q.payload;
    assign out_time    = out_q.time_v;
    assign out_time_ok = out_q.time_ok;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_q)) else $error("output changed under stall"); // R11

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready) else $error("input accepted under stall"); // R11

    AST_LINK_NO_TIME: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_kind == KIND_INFO && is_link_count(out_code) |-> !out_time_ok) else $error("count treated as time"); // R6

    AST_TS_CODE_TIME_OK: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_kind == KIND_INFO && carries_high_ts(out_code) |-> out_time_ok) else $error("stamp item lacks time"); // R4

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ts_pause, ts_resume, frame_err})) else $error("status strobes overlap"); // R10

endmodule

// File: tb/evt_ts_decoder_bench.sv
module evt_ts_decoder_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic [1:0]  out_kind;
    logic [11:0] out_src;
    logic [1:0]  out_flags;
    logic [3:0]  out_code;
    logic [19:0] out_payload;
    logic [47:0] out_time;
    logic        out_time_ok;
    logic        ts_pause;
    logic        ts_resume;
    logic [5:0]  ts_pulse_mod;
    logic        frame_err;

    int errors = 0;
    int checks = 0;

    int cap_n = 0;
    logic [1:0]  c_kind;
    logic [11:0] c_src;
    logic [1:0]  c_flags;
    logic [3:0]  c_code;
    logic [19:0] c_payload;
    logic [47:0] c_time;
    logic        c_ok;
    int pause_n = 0;
    int resume_n = 0;
    int ferr_n = 0;
    logic [5:0] pmod_last;

    always #5 clk = ~clk;

    evt_ts_decoder u_evt_ts_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_src(out_src),
        .out_flags(out_flags), .out_code(out_code), .out_payload(out_payload),
        .out_time(out_time), .out_time_ok(out_time_ok), .ts_pause(ts_pause),
        .ts_resume(ts_resume), .ts_pulse_mod(ts_pulse_mod), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && out_ready) begin
                cap_n++;
                c_kind = out_kind; c_src = out_src; c_flags = out_flags; c_code = out_code;
                c_payload = out_payload; c_time = out_time; c_ok = out_time_ok;
            end
            if (ts_pause) begin pause_n++; pmod_last = ts_pulse_mod; end
            if (ts_resume) begin resume_n++; pmod_last = ts_pulse_mod; end
            if (frame_err) ferr_n++;
        end
    end

    task automatic chk(input bit good, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    function automatic logic [31:0] adc_w0(input bit fail, input bit veto, input logic [11:0] id, input logic [15:0] v);
        return {2'b11, fail, veto, id, v};
    endfunction

    function automatic logic [31:0] info_w0(input logic [5:0] m, input logic [3:0] c, input logic [19:0] f);
        return {2'b10, m, c, f};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] w);
        in_data  = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_item(input logic [31:0] w0, input logic [31:0] w1);
        send_word(w0);
        send_word(w1);
        idle(2);
    endtask

    task automatic t_reset;
        eq("R1", "out_valid after reset", out_valid, 0);
        eq("R1", "in_ready after reset", in_ready, 1);
        eq("R1", "strobes after reset", {ts_pause, ts_resume, frame_err}, 0);
    endtask

    task automatic t_empty_table;
        int n0 = cap_n;
        send_item(info_w0(6'd5, 4'd0, 20'h00123), 32'h0765_4321);
        eq("R3", "info item count", cap_n - n0, 1);
        eq("R3", "info kind", c_kind, 2);
        eq("R3", "info src", c_src, 12'h005);
        eq("R3", "info payload", c_payload, 20'h00123);
        eq("R1", "empty entry time_ok", c_ok, 0);
        eq("R1", "empty entry time", c_time, 48'h0000_0765_4321);
    endtask

    task automatic t_adc_fields;
        send_item(adc_w0(1'b1, 1'b0, 12'h143, 16'hBEEF), 32'h0000_0042);
        eq("R2", "adc kind", c_kind, 1);
        eq("R2", "adc src", c_src, 12'h143);
        eq("R2", "adc flags", c_flags, 2'b10);
        eq("R2", "adc payload", c_payload, 20'h0BEEF);
        eq("R2", "adc code", c_code, 0);
        eq("R1", "adc time_ok before sync", c_ok, 0);
    endtask

    task automatic t_sync_and_merge;
        send_item(info_w0(6'd5, 4'd4, 20'hABCDE), 32'h0123_4567);
        eq("R4", "sync time", c_time, 48'hABCDE_1234567);
        eq("R4", "sync time_ok", c_ok, 1);
        eq("R3", "sync code", c_code, 4);
        send_item(adc_w0(1'b0, 1'b1, 12'h143, 16'h0007), 32'h0000_0042);
        eq("R5", "adc merged time", c_time, 48'hABCDE_0000042);
        eq("R5", "adc merged ok", c_ok, 1);
        eq("R2", "adc veto flag", c_flags, 2'b01);
        send_item(info_w0(6'd5, 4'd9, 20'h00003), 32'h0FFF_FFFF);
        eq("R5", "info merged time", c_time, 48'hABCDE_FFFFFFF);
    endtask

    task automatic t_other_module;
        send_item(adc_w0(1'b0, 1'b0, 12'h183, 16'h0001), 32'h0000_0010);
        eq("R12", "module 6 untouched ok", c_ok, 0);
        eq("R12", "module 6 untouched time", c_time, 48'h0000_0000010);
    endtask

    task automatic t_pause_resume;
        int p0 = pause_n;
        int r0 = resume_n;
        send_item(info_w0(6'd6, 4'd2, 20'h11111), 32'h0000_0001);
        eq("R10", "pause strobes", pause_n - p0, 1);
        eq("R10", "pause module", pmod_last, 6);
        eq("R10", "no resume on pause", resume_n - r0, 0);
        send_item(info_w0(6'd6, 4'd3, 20'h22222), 32'h0000_0002);
        eq("R10", "resume strobes", resume_n - r0, 1);
        eq("R10", "pause count unchanged", pause_n - p0, 1);
        send_item(adc_w0(1'b0, 1'b0, 12'h180, 16'h0002), 32'h0000_0003);
        eq("R12", "module 6 now set", c_time, 48'h22222_0000003);
        send_item(adc_w0(1'b0, 1'b0, 12'h143, 16'h0002), 32'h0000_0003);
        eq("R12", "module 5 kept", c_time, 48'hABCDE_0000003);
    endtask

    task automatic t_link_stats;
        send_item(info_w0(6'd5, 4'd14, 20'h00002), 32'h0ABC_DEF0);
        eq("R6", "link time_ok", c_ok, 0);
        eq("R6", "link count passthrough", c_time, 48'h0000_0ABCDEF0);
        send_item(info_w0(6'd5, 4'd15, 20'h00001), 32'h0000_0005);
        eq("R6", "link15 time_ok", c_ok, 0);
        send_item(adc_w0(1'b0, 1'b0, 12'h145, 16'h0003), 32'h0000_0099);
        eq("R6", "table unchanged after link", c_time, 48'hABCDE_0000099);
        eq("R6", "table still valid", c_ok, 1);
    endtask

    task automatic t_trace_skip;
        int n0 = cap_n;
        int f0 = ferr_n;
        send_word(32'h4000_0006);
        send_word(32'h0000_0010);
        send_word(adc_w0(1'b0, 1'b0, 12'h001, 16'h0002));
        send_word(info_w0(6'd5, 4'd4, 20'h00000));
        send_word(32'hC003_0004);
        send_item(adc_w0(1'b0, 1'b0, 12'h144, 16'h0AAA), 32'h0000_0077);
        eq("R7", "only trailing item emitted", cap_n - n0, 1);
        eq("R7", "trailing item payload", c_payload, 20'h00AAA);
        eq("R7", "skipped sync left table", c_time, 48'hABCDE_0000077);
        eq("R7", "no framing error", ferr_n - f0, 0);
        n0 = cap_n;
        send_word(32'h4000_0005);
        send_word(32'h0000_0000);
        send_word(32'hFFFF_FFFF);
        send_word(32'hFFFF_FFFF);
        send_word(32'hFFFF_FFFF);
        send_item(info_w0(6'd7, 4'd0, 20'h00042), 32'h0000_0001);
        eq("R7", "odd count skips ceil", cap_n - n0, 1);
        eq("R7", "odd count item src", c_src, 12'h007);
    endtask

    task automatic t_bad_second;
        int n0 = cap_n;
        int f0 = ferr_n;
        send_word(info_w0(6'd5, 4'd4, 20'h33333));
        send_word(32'h5000_0000);
        idle(2);
        eq("R8", "frame_err on bad second", ferr_n - f0, 1);
        eq("R8", "bad item dropped", cap_n - n0, 0);
        send_word(32'h0000_0123);
        send_word(32'h0FFF_0000);
        idle(2);
        eq("R8", "hunt is silent", ferr_n - f0, 1);
        send_item(adc_w0(1'b0, 1'b0, 12'h146, 16'h0055), 32'h0000_0011);
        eq("R8", "resync item emitted", cap_n - n0, 1);
        eq("R8", "dropped sync not stored", c_time, 48'hABCDE_0000011);
    endtask

    task automatic t_stray_first;
        int n0 = cap_n;
        int f0 = ferr_n;
        send_word(32'h0000_0005);
        idle(2);
        eq("R9", "stray 00 word flagged", ferr_n - f0, 1);
        send_word(32'h6000_0000);
        idle(2);
        eq("R9", "stray 0110 word flagged", ferr_n - f0, 2);
        eq("R9", "stray words dropped", cap_n - n0, 0);
        send_item(info_w0(6'd2, 4'd1, 20'h00004), 32'h0000_0003);
        eq("R9", "next item decodes", c_payload, 20'h00004);
    endtask

    task automatic t_backpressure;
        int n0 = cap_n;
        logic [47:0] held;
        out_ready = 1'b0;
        send_word(adc_w0(1'b0, 1'b0, 12'h147, 16'h1234));
        send_word(32'h0000_0AAA);
        eq("R11", "valid under stall", out_valid, 1);
        held = out_time;
        in_data = info_w0(6'd5, 4'd0, 20'h0);
        in_valid = 1'b1;
        idle(3);
        eq("R11", "in_ready low under stall", in_ready, 0);
        eq("R11", "time held", out_time, held);
        eq("R11", "payload held", out_payload, 20'h01234);
        in_valid = 1'b0;
        out_ready = 1'b1;
        idle(2);
        eq("R11", "released item delivered", cap_n - n0, 1);
        eq("R11", "released time", c_time, 48'hABCDE_0000AAA);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        out_ready = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_empty_table();
        t_adc_fields();
        t_sync_and_merge();
        t_other_module();
        t_pause_resume();
        t_link_stats();
        t_trace_skip();
        t_bad_second();
        t_stray_first();
        t_backpressure();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule